// File: doc/BRIEF.md
# Absolute Encoder Frame Reader with Acknowledge and CRC Check

This block is the master side of a synchronous, clock-in/data-out absolute encoder link. When asked, it starts a read by pulling its clock line toward the encoder low. It keeps toggling that line at a rate set by a divider parameter and waits for the encoder to answer with a one-cycle low acknowledge on the return data line. It then shifts in a frame made of a warning bit, an error bit, a position word (26 bits by default) and a 6-bit check code. The check code is recomputed over the status and position bits, and the position is accepted only when the two codes agree.

After each read, or after a read that is abandoned because the acknowledge never came, the clock line stays high for an enforced quiet gap before the next read may begin. A controller asks for reads with a level request. It gets back a one-cycle completion pulse, the latest accepted position, the two status flags, a check-failure flag and an acknowledge-timeout flag.

Top module: `enc_frame_master`

## Requirements
- R1: After reset the clock line `lnk_clk` is high, `busy`, `rd_done`, `warn`, `fault`, `chk_fail` and `ack_tmo` are 0, and `position` is 0.
- R2: Outside a read `lnk_clk` is held high. A read starts in the cycle after `rd_req` is seen high while the block is idle: `lnk_clk` goes low (the start condition) and `ack_tmo` clears.
- R3: During a read, each low phase and each high phase of `lnk_clk` lasts exactly HALF_DIV system clock cycles. `lnk_dat` is sampled at every low-to-high transition of `lnk_clk`.
- R4: The first sample that reads 0 is the acknowledge, and earlier samples that read 1 have no effect. The samples that follow it are taken in this order: warning (1 = active), error (1 = active), position MSB first, and check code MSB first.
- R5: If ACK_LIMIT consecutive samples read 1 while the block waits for the acknowledge, the read is abandoned. `ack_tmo` goes to 1, `lnk_clk` returns high, `rd_done` is not pulsed, and `position`, `warn`, `fault` and `chk_fail` keep their values.
- R6: The check code is computed serially over the warning, error and position bits, in the order they are received. The register starts at zero, and for each bit the feedback is the register MSB XOR the bit. The register shifts left, and when the feedback is 1 it is XORed with 6'h17 (x^6 + x^4 + x^2 + x + 1).
- R7: At the end of a complete frame `rd_done` is high for exactly one cycle. When the received code equals the computed code, `position` takes the received word and `chk_fail` is 0.
- R8: When the codes differ, `chk_fail` is 1 and `position` keeps the value it had before the read.
- R9: `warn` and `fault` take the received status bits on every complete frame, whether or not the code check passes.
- R10: After a read completes or is abandoned, `lnk_clk` stays high for at least GAP_CYCLES system cycles before the next start condition. A request held during the gap is served once the gap has elapsed.
- R11: `busy` is 1 from the start condition until the gap after that read has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Level request to start a read |
| lnk_dat | input | 1 | Serial data returned by the encoder |
| lnk_clk | output | 1 | Clock toward the encoder; idles high |
| busy | output | 1 | Read or quiet gap in progress |
| rd_done | output | 1 | One-cycle pulse when a frame completes |
| position | output | POS_W | Last position accepted with a matching code |
| warn | output | 1 | Warning bit of the last complete frame |
| fault | output | 1 | Error bit of the last complete frame |
| chk_fail | output | 1 | Code mismatch on the last complete frame |
| ack_tmo | output | 1 | Last read was abandoned for lack of acknowledge |

## Verification
On every cycle the assertions check several properties: the clock line stays high outside a read and throughout the gap, the completion pulse lasts one cycle, a timeout never coincides with a completion, and the position holds on a failed check. They also check that the acknowledge and divider counters stay within their bounds. Only the bench scenarios can show that the right bits reach the right outputs. These scenarios cover acknowledges at the earliest and latest allowed sample and one sample too late, corrupted codes, status reporting on failed frames, exact phase widths, and a request held through the gap.

// File: rtl/enc_frame_pkg.sv
package enc_frame_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACK  = 2'd1,
      ST_DATA = 2'd2,
      ST_GAP  = 2'd3
   } efm_state_e;
endpackage

// File: rtl/enc_link_div.sv
module enc_link_div #(
   parameter int HALF_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   if (HALF_DIV < 1) begin : g_bad
      $error("enc_link_div: HALF_DIV must be at least 1");
   end

   if (HALF_DIV == 1) begin : g_direct
      assign tick = en;
   end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          cnt <= '0;
         else if (!en)                        cnt <= '0;
         else if (cnt == CW'(HALF_DIV - 1))   cnt <= '0;
         else                                 cnt <= cnt + 1'b1;
      end

      assign tick = en && (cnt == CW'(HALF_DIV - 1));

      // R3: phase counter never passes the half-period limit
      a_r3_div_range: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CW'(HALF_DIV - 1));
   end
endmodule

// File: rtl/enc_crc_serial.sv
module enc_crc_serial #(
   parameter int          W    = 6,
   parameter logic [W-1:0] POLY = 6'h17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc
);
   if (W < 2) begin : g_bad
      $error("enc_crc_serial: W must be at least 2");
   end

   logic fb;
   assign fb = crc[W-1] ^ din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= '0;
      else if (clr) crc <= '0;
      else if (en)  crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end
endmodule

// File: rtl/enc_frame_master.sv
module enc_frame_master
   import enc_frame_pkg::*;
#(
   parameter int POS_W      = 26,
   parameter int HALF_DIV   = 10,
   parameter int ACK_LIMIT  = 16,
   parameter int GAP_CYCLES = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic             lnk_dat,
   output logic             lnk_clk,
   output logic             busy,
   output logic             rd_done,
   output logic [POS_W-1:0] position,
   output logic             warn,
   output logic             fault,
   output logic             chk_fail,
   output logic             ack_tmo
);
   localparam int STAT_W  = 2;
   localparam int CRC_W   = 6;
   localparam int PAY_W   = STAT_W + POS_W;
   localparam int FRAME_W = PAY_W + CRC_W;
   localparam int IDX_W   = $clog2(FRAME_W + 1);
   localparam int ACK_W   = $clog2(ACK_LIMIT + 1);
   localparam int GAP_W   = $clog2(GAP_CYCLES + 1);

   if (POS_W < 1)      begin : g_bad_pos $error("POS_W must be positive");      end
   if (ACK_LIMIT < 1)  begin : g_bad_ack $error("ACK_LIMIT must be positive");  end
   if (GAP_CYCLES < 1) begin : g_bad_gap $error("GAP_CYCLES must be positive"); end

   efm_state_e         state;
   logic               ma_q;
   logic [IDX_W-1:0]   bit_idx;
   logic [ACK_W-1:0]   ack_cnt;
   logic [GAP_W-1:0]   gap_cnt;
   logic [FRAME_W-2:0] shreg;
   logic [FRAME_W-1:0] full;
   logic [POS_W-1:0]   pos_q;
   logic               warn_q, fault_q, fail_q, tmo_q, done_q;
   logic               in_frame, tick, sample, accept, crc_en;
   logic [CRC_W-1:0]   crc_calc;
   logic [CRC_W-1:0]   crc_rx;

   assign in_frame = (state == ST_ACK) || (state == ST_DATA);
   assign accept   = (state == ST_IDLE) && rd_req;
   assign sample   = tick && !ma_q;
   assign crc_en   = sample && (state == ST_DATA) && (bit_idx < IDX_W'(PAY_W));
   assign full     = {shreg, lnk_dat};
   assign crc_rx   = full[CRC_W-1:0];

   enc_link_div #(.HALF_DIV(HALF_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_frame),
      .tick  (tick)
   );

   enc_crc_serial #(.W(CRC_W), .POLY(6'h17)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .en    (crc_en),
      .din   (lnk_dat),
      .crc   (crc_calc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         ma_q    <= 1'b1;
         bit_idx <= '0;
         ack_cnt <= '0;
         gap_cnt <= '0;
         shreg   <= '0;
         pos_q   <= '0;
         warn_q  <= 1'b0;
         fault_q <= 1'b0;
         fail_q  <= 1'b0;
         tmo_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (rd_req) begin
                  state   <= ST_ACK;
                  ma_q    <= 1'b0;
                  ack_cnt <= '0;
                  bit_idx <= '0;
                  tmo_q   <= 1'b0;
               end
            end
            ST_ACK: begin
               if (tick) begin
                  if (ma_q) begin
                     ma_q <= 1'b0;
                  end else begin
                     ma_q <= 1'b1;
                     if (!lnk_dat) begin
                        state <= ST_DATA;
                     end else if (ack_cnt == ACK_W'(ACK_LIMIT - 1)) begin
                        tmo_q   <= 1'b1;
                        state   <= ST_GAP;
                        gap_cnt <= '0;
                     end else begin
                        ack_cnt <= ack_cnt + 1'b1;
                     end
                  end
               end
            end
            ST_DATA: begin
               if (tick) begin
                  if (ma_q) begin
                     ma_q <= 1'b0;
                  end else begin
                     ma_q    <= 1'b1;
                     shreg   <= full[FRAME_W-2:0];
                     bit_idx <= bit_idx + 1'b1;
                     if (bit_idx == IDX_W'(FRAME_W - 1)) begin
                        state   <= ST_GAP;
                        gap_cnt <= '0;
                        done_q  <= 1'b1;
                        warn_q  <= full[FRAME_W-1];
                        fault_q <= full[FRAME_W-2];
                        fail_q  <= (crc_rx != crc_calc);
                        if (crc_rx == crc_calc) pos_q <= full[CRC_W +: POS_W];
                     end
                  end
               end
            end
            ST_GAP: begin
               if (gap_cnt == GAP_W'(GAP_CYCLES - 1)) state <= ST_IDLE;
               else                                   gap_cnt <= gap_cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign lnk_clk  = ma_q;
   assign busy     = (state != ST_IDLE);
   assign rd_done  = done_q;
   assign position = pos_q;
   assign warn     = warn_q;
   assign fault    = fault_q;
   assign chk_fail = fail_q;
   assign ack_tmo  = tmo_q;

   // R2: clock line high whenever no read is running
   a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !in_frame |-> lnk_clk);
   // R5: acknowledge wait counter stays below the limit
   a_r5_ack_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ack_cnt < ACK_W'(ACK_LIMIT));
   // R5: an abandoned read never reports completion
   a_r5_tmo_no_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_tmo) |-> !rd_done);
   // R7: completion is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done);
   // R8: failed check leaves the position untouched
   a_r8_hold_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && chk_fail) |-> $stable(position));
   // R10: no clock activity in the quiet gap
   a_r10_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GAP) |=> lnk_clk);
   // R11: a low clock line only occurs while busy
   a_r11_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
      !lnk_clk |-> busy);
endmodule

// File: tb/enc_frame_master_tb.sv
`timescale 1ns/1ps
module enc_frame_master_tb;
   localparam int POS_W = 26;
   localparam int HD    = 2;
   localparam int ACKL  = 6;
   localparam int GAP   = 20;
   localparam int FW    = POS_W + 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rd_req = 1'b0;
   logic lnk_dat = 1'b1;
   logic lnk_clk, busy, rd_done, warn, fault, chk_fail, ack_tmo;
   logic [POS_W-1:0] position;

   always #2.5 clk = ~clk;

   enc_frame_master #(.POS_W(POS_W), .HALF_DIV(HD), .ACK_LIMIT(ACKL), .GAP_CYCLES(GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .lnk_dat(lnk_dat),
      .lnk_clk(lnk_clk), .busy(busy), .rd_done(rd_done), .position(position),
      .warn(warn), .fault(fault), .chk_fail(chk_fail), .ack_tmo(ack_tmo)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   // encoder model: updates data on each falling clock edge
   int enc_lat = 1;
   int fall_cnt = 0;
   logic [FW-1:0] enc_frame = '0;
   always @(negedge lnk_clk) begin
      fall_cnt = fall_cnt + 1;
      if (fall_cnt < enc_lat)       lnk_dat = 1'b1;
      else if (fall_cnt == enc_lat) lnk_dat = 1'b0;
      else if (fall_cnt - enc_lat - 1 < FW) lnk_dat = enc_frame[FW - 1 - (fall_cnt - enc_lat - 1)];
      else                          lnk_dat = 1'b1;
   end

   // R3 monitor of phase widths
   int run_lo = 0, run_hi = 0, lo_seen = 0, bad_ph = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!lnk_clk) begin
            if (run_hi != 0 && busy && run_hi != HD) bad_ph++;
            run_hi = 0;
            run_lo++;
         end else begin
            if (run_lo != 0) begin
               lo_seen++;
               if (run_lo != HD) bad_ph++;
            end
            run_lo = 0;
            if (busy) run_hi++; else run_hi = 0;
         end
      end
   end

   task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] crc6(input logic [POS_W+1:0] d);
      logic [5:0] c = '0;
      logic fb;
      for (int i = POS_W + 1; i >= 0; i--) begin
         fb = c[5] ^ d[i];
         c  = {c[4:0], 1'b0} ^ (fb ? 6'h17 : 6'h00);
      end
      return c;
   endfunction

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         report();
      end
   end

   logic [POS_W-1:0] exp_pos = '0;
   logic exp_w = 0, exp_e = 0, exp_f = 0;

   task automatic run_read(input logic w, input logic e, input logic [POS_W-1:0] p,
                           input logic corrupt, input int lat, input string tag);
      logic [5:0] c;
      logic got_done, got_tmo, expect_tmo;
      c = crc6({w, e, p});
      if (corrupt) c = c ^ 6'h01;
      while (busy) @(negedge clk);
      enc_frame = {w, e, p, c};
      enc_lat = lat;
      fall_cnt = 0;
      lnk_dat = 1'b1;
      rd_req = 1'b1;
      @(negedge clk);
      rd_req = 1'b0;
      check(!lnk_clk && !ack_tmo, {tag, " R2 start"}, {lnk_clk, ack_tmo}, 0);
      got_done = 0; got_tmo = 0;
      for (int k = 0; k < 2000 && !got_done && !got_tmo; k++) begin
         @(negedge clk);
         got_done = rd_done;
         got_tmo  = ack_tmo;
      end
      expect_tmo = (lat > ACKL);
      if (expect_tmo) begin
         check(got_tmo && !got_done, {tag, " R5 timeout"}, {got_tmo, got_done}, 2'b10);
         check(lnk_clk, {tag, " R5 line high"}, lnk_clk, 1);
      end else begin
         check(got_done && !got_tmo, {tag, " R7 done"}, {got_done, got_tmo}, 2'b10);
         exp_w = w; exp_e = e; exp_f = corrupt;
         if (!corrupt) exp_pos = p;
         @(negedge clk);
         check(!rd_done, {tag, " R7 pulse"}, rd_done, 0);
      end
      check(position == exp_pos, {tag, " R7 R8 position"}, position, exp_pos);
      check(warn == exp_w && fault == exp_e, {tag, " R9 status"}, {warn, fault}, {exp_w, exp_e});
      check(chk_fail == exp_f, {tag, " R6 R8 check flag"}, chk_fail, exp_f);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(lnk_clk && !busy && !rd_done && !warn && !fault && !chk_fail && !ack_tmo && position == 0,
            "R1 reset", {lnk_clk, busy, rd_done, warn, fault, chk_fail, ack_tmo}, 7'b1000000);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(lnk_clk && !busy, "R2 idle high", {lnk_clk, busy}, 2'b10);

      run_read(0, 0, 26'h0000000, 0, 1, "zero");
      run_read(1, 0, 26'h3FFFFFF, 0, 3, "ones warn");
      run_read(0, 1, 26'h2AAAAAA, 0, 2, "R4 fault");
      run_read(1, 1, 26'h1555555, 1, 1, "R8 corrupt");
      run_read(0, 0, 26'h0123456, 0, ACKL, "R4 late ack");
      run_read(1, 0, 26'h3ABCDEF, 0, ACKL + 1, "R5 no ack");
      run_read(0, 0, 26'h0FEDCBA, 0, 1, "after tmo");

      // R10 gap with held request
      begin
         int gap_n;
         while (busy) @(negedge clk);
         enc_frame = {2'b00, 26'h0000011, crc6({2'b00, 26'h0000011})};
         enc_lat = 1; fall_cnt = 0; lnk_dat = 1'b1;
         rd_req = 1'b1;
         while (!rd_done) @(negedge clk);
         exp_pos = 26'h0000011; exp_w = 0; exp_e = 0; exp_f = 0;
         fall_cnt = 0;
         gap_n = 0;
         while (lnk_clk && gap_n < 500) begin
            @(negedge clk);
            gap_n++;
            check(gap_n <= GAP || busy || !lnk_clk, "R11 busy in gap", busy, 1);
         end
         rd_req = 1'b0;
         check(gap_n >= GAP && gap_n <= GAP + 2, "R10 gap length", gap_n, GAP + 1);
         while (!rd_done) @(negedge clk);
         check(position == 26'h0000011, "R10 deferred read", position, 26'h0000011);
      end

      // random reads
      for (int i = 0; i < 24; i++) begin
         logic [POS_W-1:0] p;
         logic w, e, cr;
         int lat;
         p   = POS_W'($urandom);
         w   = 1'($urandom);
         e   = 1'($urandom);
         cr  = ($urandom % 4) == 0;
         lat = 1 + ($urandom % (ACKL + 1));
         run_read(w, e, p, cr, lat, "R6 random");
      end

      check(lo_seen > 0 && bad_ph == 0, "R3 phase width", bad_ph, 0);
      report();
   end
endmodule